// File: doc/BRIEF.md
# Data-Ready Status and Interrupt Generator

This block sits between a two-axis angular-rate sampling path and the host register interface of a motion sensor. It watches one-cycle strobes that mark a fresh X sample, a fresh Y sample and a fresh temperature sample. From these it keeps per-axis new-data and overrun flags, and packs them into an 8-bit status word. It also drives a single data-ready pin that a host can use for synchronous reads.

The register front end reports which reads happen through one-cycle notifications: X high byte, Y high byte, temperature high byte and the status word. The flags clear in response to these reads. The pin works in one of two modes. In the latched mode it stays active until a qualifying read. In the pulsed mode it gives a fixed-length pulse and ignores reads. Control inputs set the active level, choose push-pull or open-drain drive (the drive is shown through an output-enable), gate the pin on or off, and can add temperature readiness to the pin. The pulse length is worked out from a clock-frequency parameter and a duration in microseconds.

Top module: `drdy_status_gen`

## Requirements
- R1: After reset the status word is 0x00, drdy_o is 0 and drdy_oe_o is 1.
- R2: The X new-data flag (status bit 2) and the Y new-data flag (status bit 1) each set one clock after that axis's strobe. Each clears one clock after a read of that axis's high byte. When a strobe and a read fall in the same cycle, the flag stays set.
- R3: Status bit 3 is 1 exactly when both axis new-data flags are 1. Status bits 4 and 0 always read 0.
- R4: The X overrun flag (bit 6) and the Y overrun flag (bit 5) set when a strobe arrives on an axis whose new-data flag is already 1 and whose high byte is not read in that same cycle. They clear on a status read, and a set in the same cycle as a status read wins.
- R5: The global overrun flag (bit 7) sets when any rate strobe arrives while both new-data flags are 1 and neither high byte is read in that cycle. It clears on a status read, and a set in the same cycle wins.
- R6: In latched mode the rate-ready condition sets on any rate strobe. It clears on a read of the X high byte, the Y high byte or the status word. A strobe in the same cycle wins.
- R7: A temperature-ready condition sets on the temperature strobe and clears on a temperature high-byte or status read. It reaches the pin only while cfg_temp_route is 1. In pulsed mode a temperature strobe starts a pulse only while cfg_temp_route is 1.
- R8: In pulsed mode each trigger starts or restarts a pulse lasting (CLK_HZ/1000)*PULSE_US/1000 clocks, and reads have no effect on it.
- R9: While cfg_pin_en is 0 the pin sits at its inactive level.
- R10: cfg_act_low = 0 makes the active level high; cfg_act_low = 1 makes it low.
- R11: Push-pull (cfg_open_drain = 0) gives drdy_oe_o = 1 and drdy_o = the level. Open-drain gives drdy_o = 0, with drdy_oe_o = 1 only when the level is low.
- R12: The status word follows its strobes and reads by one clock. The pin follows the ready condition by one further clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| x_new | input | 1 | New X-axis sample strobe |
| y_new | input | 1 | New Y-axis sample strobe |
| t_new | input | 1 | New temperature sample strobe |
| rd_x_hi | input | 1 | Host read of X high byte |
| rd_y_hi | input | 1 | Host read of Y high byte |
| rd_t_hi | input | 1 | Host read of temperature high byte |
| rd_status | input | 1 | Host read of the status word |
| cfg_pulsed | input | 1 | 1: pulsed pin mode, 0: latched |
| cfg_act_low | input | 1 | 1: active-low pin |
| cfg_open_drain | input | 1 | 1: open-drain drive |
| cfg_pin_en | input | 1 | 1: pin carries data-ready |
| cfg_temp_route | input | 1 | 1: temperature readiness also on pin |
| status_o | output | 8 | Status word |
| drdy_o | output | 1 | Pin value |
| drdy_oe_o | output | 1 | Pin output enable |

## Verification
The two functions that can fall in the same cycle are a flag being set by a sample strobe and the same flag being cleared by a host read. There are also the overrun decision and the read of the unread value that it depends on. Directed steps put a strobe and its clearing read on one edge, and put a status read on the same edge as a fresh overrun event. A long seeded random run then fires strobes and reads at rates high enough that such collisions happen thousands of times. Every cycle, the status word and the pin are compared against a bench model built from the set-wins and read-cancels-overrun rules.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
   // status word bit positions (host software decodes these)
   localparam int ST_G_OVR = 7;
   localparam int ST_X_OVR = 6;
   localparam int ST_Y_OVR = 5;
   localparam int ST_G_NEW = 3;
   localparam int ST_X_NEW = 2;
   localparam int ST_Y_NEW = 1;
   localparam int ST_W     = 8;

   // axis indices inside the flag tracker
   localparam int AX_X = 0;
   localparam int AX_Y = 1;

   typedef struct packed {
      logic pulsed;
      logic act_low;
      logic open_drain;
      logic pin_en;
      logic temp_route;
   } drdy_cfg_t;
endpackage

// File: rtl/drdy_axis_flags.sv
module drdy_axis_flags #(
   parameter int N_AXES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_AXES-1:0] strobe,
   input  logic [N_AXES-1:0] rd_hi,
   input  logic              rd_status,
   output logic [N_AXES-1:0] new_flag,
   output logic [N_AXES-1:0] ovr_flag,
   output logic              all_new,
   output logic              glob_ovr
);
   initial assert (N_AXES >= 1) else $error("N_AXES must be at least 1");

   logic [N_AXES-1:0] ovr_evt;
   logic              glob_evt;

   for (genvar i = 0; i < N_AXES; i++) begin : g_axis
      assign ovr_evt[i] = strobe[i] & new_flag[i] & ~rd_hi[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            new_flag[i] <= 1'b0;
            ovr_flag[i] <= 1'b0;
         end else begin
            if (strobe[i])      new_flag[i] <= 1'b1;
            else if (rd_hi[i])  new_flag[i] <= 1'b0;
            if (ovr_evt[i])     ovr_flag[i] <= 1'b1;
            else if (rd_status) ovr_flag[i] <= 1'b0;
         end
      end

      // R2: strobe always leaves the flag set
      a_r2_new_sets: assert property (@(posedge clk) disable iff (!rst_n)
         strobe[i] |=> new_flag[i]);
      // R4: unread value overwritten raises overrun
      a_r4_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (strobe[i] && new_flag[i] && !rd_hi[i]) |=> ovr_flag[i]);
   end

   assign all_new  = &new_flag;
   assign glob_evt = (|strobe) & all_new & ~(|rd_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         glob_ovr <= 1'b0;
      else if (glob_evt)  glob_ovr <= 1'b1;
      else if (rd_status) glob_ovr <= 1'b0;
   end

   // R5: status read with no new event empties the global overrun
   a_r5_glob_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !(|strobe)) |=> !glob_ovr);
endmodule

// File: rtl/drdy_pulse_stretch.sv
module drdy_pulse_stretch #(
   parameter int LEN   = 18750,
   parameter int CNT_W = $clog2(LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active,
   output logic last
);
   initial assert (LEN >= 1) else $error("pulse length must be at least one clock");
   initial assert ((1 << CNT_W) > LEN) else $error("counter too narrow for pulse");

   localparam logic [CNT_W-1:0] LEN_V = CNT_W'(LEN);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (trig)       cnt <= LEN_V;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);
   assign last   = (cnt == CNT_W'(1));

   // R8: a trigger always (re)starts the pulse
   a_r8_trig_starts: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> active);
endmodule

// File: rtl/drdy_pin_drive.sv
module drdy_pin_drive #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic func,
   input  logic pin_en,
   input  logic act_low,
   input  logic open_drain,
   output logic pin_o,
   output logic pin_oe_o
);
   logic lvl, pin_n, oe_n;

   always_comb begin
      lvl = (pin_en & func) ^ act_low;
      if (open_drain) begin
         pin_n = 1'b0;
         oe_n  = ~lvl;
      end else begin
         pin_n = lvl;
         oe_n  = 1'b1;
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_o    <= 1'b0;
            pin_oe_o <= 1'b1;
         end else begin
            pin_o    <= pin_n;
            pin_oe_o <= oe_n;
         end
      end

      // R11: open drain never drives high
      a_r11_od_low: assert property (@(posedge clk) disable iff (!rst_n)
         open_drain |=> !pin_o);
      // R9: disabled, active-high push-pull rests low and driven
      a_r9_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (!pin_en && !act_low && !open_drain) |=> (!pin_o && pin_oe_o));
   end else begin : g_comb
      assign pin_o    = pin_n;
      assign pin_oe_o = oe_n;

      // R11: open drain never drives high
      a_r11_od_low: assert property (@(posedge clk) disable iff (!rst_n)
         open_drain |-> !pin_o);
   end
endmodule

// File: rtl/drdy_status_gen.sv
module drdy_status_gen #(
   parameter int CLK_HZ   = 250_000_000,
   parameter int PULSE_US = 75,
   parameter bit PIN_REG  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       x_new,
   input  logic       y_new,
   input  logic       t_new,
   input  logic       rd_x_hi,
   input  logic       rd_y_hi,
   input  logic       rd_t_hi,
   input  logic       rd_status,
   input  logic       cfg_pulsed,
   input  logic       cfg_act_low,
   input  logic       cfg_open_drain,
   input  logic       cfg_pin_en,
   input  logic       cfg_temp_route,
   output logic [7:0] status_o,
   output logic       drdy_o,
   output logic       drdy_oe_o
);
   import drdy_pkg::*;

   localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;
   localparam int CNT_W     = $clog2(PULSE_CYC + 1);

   initial assert (CLK_HZ >= 1000) else $error("CLK_HZ below 1 kHz");
   initial assert (PULSE_CYC >= 1) else $error("pulse shorter than one clock");

   drdy_cfg_t cfg;
   assign cfg = '{pulsed: cfg_pulsed, act_low: cfg_act_low, open_drain: cfg_open_drain,
                  pin_en: cfg_pin_en, temp_route: cfg_temp_route};

   logic [1:0] ax_strobe, ax_rd, ax_new, ax_ovr;
   logic       all_new, glob_ovr;

   assign ax_strobe[AX_X] = x_new;
   assign ax_strobe[AX_Y] = y_new;
   assign ax_rd[AX_X]     = rd_x_hi;
   assign ax_rd[AX_Y]     = rd_y_hi;

   drdy_axis_flags #(.N_AXES(2)) u_flags (
      .clk(clk), .rst_n(rst_n), .strobe(ax_strobe), .rd_hi(ax_rd),
      .rd_status(rd_status), .new_flag(ax_new), .ovr_flag(ax_ovr),
      .all_new(all_new), .glob_ovr(glob_ovr)
   );

   always_comb begin
      status_o           = '0;
      status_o[ST_G_OVR] = glob_ovr;
      status_o[ST_X_OVR] = ax_ovr[AX_X];
      status_o[ST_Y_OVR] = ax_ovr[AX_Y];
      status_o[ST_G_NEW] = all_new;
      status_o[ST_X_NEW] = ax_new[AX_X];
      status_o[ST_Y_NEW] = ax_new[AX_Y];
   end

   // latched ready conditions
   logic rate_rdy, temp_rdy, rate_evt, rate_clr;
   assign rate_evt = x_new | y_new;
   assign rate_clr = rd_x_hi | rd_y_hi | rd_status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_rdy <= 1'b0;
         temp_rdy <= 1'b0;
      end else begin
         if (rate_evt)                    rate_rdy <= 1'b1;
         else if (rate_clr)               rate_rdy <= 1'b0;
         if (t_new)                       temp_rdy <= 1'b1;
         else if (rd_t_hi || rd_status)   temp_rdy <= 1'b0;
      end
   end

   // pulsed ready condition
   logic pulse_trig, pulse_act, pulse_last;
   assign pulse_trig = rate_evt | (cfg.temp_route & t_new);

   drdy_pulse_stretch #(.LEN(PULSE_CYC), .CNT_W(CNT_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trig(pulse_trig),
      .active(pulse_act), .last(pulse_last)
   );

   logic func;
   assign func = cfg.pulsed ? pulse_act
                            : (rate_rdy | (cfg.temp_route & temp_rdy));

   drdy_pin_drive #(.REG_OUT(PIN_REG)) u_pin (
      .clk(clk), .rst_n(rst_n), .func(func), .pin_en(cfg.pin_en),
      .act_low(cfg.act_low), .open_drain(cfg.open_drain),
      .pin_o(drdy_o), .pin_oe_o(drdy_oe_o)
   );

   // R6: a clearing read without a new sample drops the latched condition
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_clr && !rate_evt) |=> !rate_rdy);
   // R7: temperature strobe raises its ready condition
   a_r7_temp_sets: assert property (@(posedge clk) disable iff (!rst_n)
      t_new |=> temp_rdy);
   // R8: reads cannot cut a running pulse short
   a_r8_reads_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_act && !pulse_last) |=> pulse_act);
endmodule

// File: tb/drdy_status_gen_tb.sv
`timescale 1ns/1ps
module drdy_status_gen_tb;
   localparam int CLK_HZ = 2_000_000;
   localparam int PLEN   = (CLK_HZ / 1000) * 75 / 1000;  // 150

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic x_new = 0, y_new = 0, t_new = 0;
   logic rd_x_hi = 0, rd_y_hi = 0, rd_t_hi = 0, rd_status = 0;
   logic cfg_pulsed = 0, cfg_act_low = 0, cfg_open_drain = 0, cfg_pin_en = 0, cfg_temp_route = 0;
   logic [7:0] status_o;
   logic drdy_o, drdy_oe_o;

   always #2 clk = ~clk;  // 250 MHz

   drdy_status_gen #(.CLK_HZ(CLK_HZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .x_new(x_new), .y_new(y_new), .t_new(t_new),
      .rd_x_hi(rd_x_hi), .rd_y_hi(rd_y_hi), .rd_t_hi(rd_t_hi), .rd_status(rd_status),
      .cfg_pulsed(cfg_pulsed), .cfg_act_low(cfg_act_low), .cfg_open_drain(cfg_open_drain),
      .cfg_pin_en(cfg_pin_en), .cfg_temp_route(cfg_temp_route),
      .status_o(status_o), .drdy_o(drdy_o), .drdy_oe_o(drdy_oe_o)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   // reference model state
   logic m_xn = 0, m_yn = 0, m_xo = 0, m_yo = 0, m_go = 0, m_rr = 0, m_tr = 0;
   logic m_pin = 0, m_oe = 1;
   int   m_cnt = 0;

   function automatic logic [1:0] pad_f(input logic func, en, al, od);
      logic lvl;
      lvl = (en & func) ^ al;
      return od ? {1'b0, ~lvl} : {lvl, 1'b1};
   endfunction

   function automatic logic [7:0] exp_status();
      return {m_go, m_xo, m_yo, 1'b0, m_xn & m_yn, m_xn, m_yn, 1'b0};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
      end
   endtask

   // compare with model, drive inputs, advance model, cross one edge
   task automatic step(input logic xs, ys, ts, rx, ry, rt, rs);
      logic func, trig, xo_e, yo_e, g_e;
      logic [1:0] pad;
      chk("R2 R3 R4 R5 R12 status", status_o, exp_status());
      chk("R6 R7 R8 R9 R10 R11 pin", {6'd0, drdy_o, drdy_oe_o}, {6'd0, m_pin, m_oe});
      x_new = xs; y_new = ys; t_new = ts;
      rd_x_hi = rx; rd_y_hi = ry; rd_t_hi = rt; rd_status = rs;
      func = cfg_pulsed ? (m_cnt != 0) : (m_rr | (cfg_temp_route & m_tr));
      pad  = pad_f(func, cfg_pin_en, cfg_act_low, cfg_open_drain);
      trig = xs | ys | (cfg_temp_route & ts);
      xo_e = xs & m_xn & ~rx;
      yo_e = ys & m_yn & ~ry;
      g_e  = (xs | ys) & m_xn & m_yn & ~rx & ~ry;
      m_xo = xo_e ? 1'b1 : (rs ? 1'b0 : m_xo);
      m_yo = yo_e ? 1'b1 : (rs ? 1'b0 : m_yo);
      m_go = g_e  ? 1'b1 : (rs ? 1'b0 : m_go);
      m_xn = xs ? 1'b1 : (rx ? 1'b0 : m_xn);
      m_yn = ys ? 1'b1 : (ry ? 1'b0 : m_yn);
      m_rr = (xs | ys) ? 1'b1 : ((rx | ry | rs) ? 1'b0 : m_rr);
      m_tr = ts ? 1'b1 : ((rt | rs) ? 1'b0 : m_tr);
      m_cnt = trig ? PLEN : (m_cnt != 0 ? m_cnt - 1 : 0);
      m_pin = pad[1];
      m_oe  = pad[0];
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(200_000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int hi_cnt;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1 status", status_o, 8'h00);
      chk("R1 pin", {6'd0, drdy_o, drdy_oe_o}, 8'h01);

      cfg_pin_en = 1;
      // R2 set, then strobe with read in same cycle keeps flag, no overrun (R4)
      step(1, 0, 0, 0, 0, 0, 0);
      chk("R2 x new", status_o & 8'h04, 8'h04);
      step(1, 0, 0, 1, 0, 0, 0);
      chk("R4 no ovr on read collision", status_o & 8'h44, 8'h04);
      step(1, 0, 0, 0, 0, 0, 0);
      chk("R4 x ovr", status_o & 8'h40, 8'h40);
      step(0, 1, 0, 0, 0, 0, 0);
      chk("R3 global new", status_o, 8'h4E);
      step(1, 0, 0, 0, 0, 0, 0);
      chk("R5 global ovr", status_o & 8'h80, 8'h80);
      step(1, 0, 0, 0, 0, 0, 1);
      chk("R4 set wins over status read", status_o & 8'hE0, 8'hC0);
      step(0, 0, 0, 0, 0, 0, 1);
      chk("R5 status read clears", status_o & 8'hF1, 8'h00);
      step(0, 0, 0, 1, 0, 0, 0);
      chk("R2 R3 x read clears", status_o, 8'h02);
      // R6 latched pin
      step(0, 1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R6 R12 pin latched high", {7'd0, drdy_o}, 8'h01);
      step(0, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R6 read drops pin", {7'd0, drdy_o}, 8'h00);
      // R10 polarity
      cfg_act_low = 1;
      idle(2);
      chk("R10 active low idle", {7'd0, drdy_o}, 8'h01);
      // R11 open drain
      cfg_act_low = 0; cfg_open_drain = 1;
      step(1, 0, 0, 0, 0, 0, 0);
      idle(1);
      chk("R11 od active released", {6'd0, drdy_o, drdy_oe_o}, 8'h00);
      step(0, 0, 0, 1, 0, 0, 0);
      idle(1);
      chk("R11 od inactive drives low", {6'd0, drdy_o, drdy_oe_o}, 8'h01);
      cfg_open_drain = 0;
      // R9 disable hides pending ready
      step(1, 0, 0, 0, 0, 0, 0);
      cfg_pin_en = 0;
      idle(2);
      chk("R9 disabled pin", {7'd0, drdy_o}, 8'h00);
      cfg_pin_en = 1;
      step(0, 0, 0, 0, 0, 0, 1);
      // R7 temperature routing
      step(0, 0, 1, 0, 0, 0, 0);
      idle(1);
      chk("R7 temp unrouted", {7'd0, drdy_o}, 8'h00);
      cfg_temp_route = 1;
      idle(2);
      chk("R7 temp routed", {7'd0, drdy_o}, 8'h01);
      step(0, 0, 0, 0, 0, 1, 0);
      idle(1);
      chk("R7 temp read clears", {7'd0, drdy_o}, 8'h00);
      cfg_temp_route = 0;
      // R8 pulse width, reads ignored
      idle(PLEN + 2);
      cfg_pulsed = 1;
      idle(2);
      step(1, 0, 0, 0, 0, 0, 0);
      hi_cnt = 0;
      for (int i = 0; i < PLEN + 20; i++) begin
         step(0, 0, 0, (i % 3) == 0, (i % 5) == 0, 0, (i % 7) == 0);
         if (drdy_o) hi_cnt++;
      end
      chk("R8 pulse width", 8'(hi_cnt), 8'(PLEN));

      // constrained random phase
      for (int i = 0; i < 12000; i++) begin
         if ((i % 96) == 0) begin
            logic [4:0] c;
            c = 5'($urandom);
            cfg_pulsed = c[0]; cfg_act_low = c[1]; cfg_open_drain = c[2];
            cfg_pin_en = c[3] | c[4]; cfg_temp_route = 1'($urandom);
         end
         step(($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 9) == 0,
              ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0,
              ($urandom % 8) == 0);
      end
      idle(2);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule